// File: doc/BRIEF.md
# Set-Associative Address Translation Cache with Global Entries

This block caches recent virtual-to-physical page translations. A requester presents a virtual page number and an address-space tag; one cycle later the block answers hit or miss and, on a hit, the physical frame number plus four attribute bits: write permission, user access, dirty and global. The low bits of the page number pick a set. The remaining bits are compared against the stored tag of every way of that set at once, and a way multiplexer selects the entry that matches.

A fill port installs a translation produced by an external page walk. The victim way is chosen in this order: a way already holding the same page, then the lowest free way, then a per-set round-robin pointer. A maintenance port takes three commands. The first removes one page. The second drops every non-global entry on an address-space switch. The third empties the whole cache. Global entries match any address-space tag and survive the switch flush. Only the single-page command or a full flush removes them.

Top module: `tlb_sa`

## Requirements
- R1: A lookup request (`lk_valid` high) at a clock edge yields `rsp_valid` high after that edge, for exactly one cycle per request; with no request, `rsp_valid` and `rsp_hit` are low.
- R2: A hit returns the frame number and the write, user, dirty and global bits of the matching entry. A response with `rsp_hit` low carries zero frame number and zero attribute bits.
- R3: A non-global entry matches only a lookup with the same address-space tag. A global entry matches a lookup with any address-space tag.
- R4: A fill whose page matches resident entries of its set (by the R3 rule, a global fill matching any tag) overwrites the lowest such way and removes the other matches. At most one way of a set ever matches a lookup.
- R5: A fill with no match takes the lowest-numbered free way of its set. If the set is full it takes the way named by that set's round-robin pointer (0 after reset). The pointer then advances by one modulo the way count; fills that do not use it leave it unchanged.
- R6: Maintenance command 2'b01 removes every entry of the given page in its set, whatever its address-space tag and global bit.
- R7: Maintenance command 2'b10 removes every entry whose global bit is clear and keeps global entries.
- R8: Maintenance command 2'b11 removes every entry. Command 2'b00 does nothing.
- R9: A lookup in the same cycle as a maintenance command sees the cache after that command, so an entry the command removes reports a miss.
- R10: A lookup in the same cycle as a fill sees the cache before the fill. A fill in the same cycle as a maintenance command is applied after the command and stays resident.
- R11: The set index is the low log2(SETS) bits of the page number. Fills and single-page invalidates touch only their own set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| lk_valid | input | 1 | Lookup request |
| lk_vpn | input | VPN_W | Lookup virtual page number |
| lk_asid | input | ASID_W | Lookup address-space tag |
| fill_valid | input | 1 | Install an entry |
| fill_vpn | input | VPN_W | Page number of the installed entry |
| fill_asid | input | ASID_W | Address-space tag of the installed entry |
| fill_pfn | input | PFN_W | Frame number of the installed entry |
| fill_rw | input | 1 | Write permitted |
| fill_us | input | 1 | User access permitted |
| fill_dirty | input | 1 | Dirty attribute |
| fill_global | input | 1 | Global attribute |
| mnt_cmd | input | 2 | 00 none, 01 invalidate page, 10 flush non-global, 11 flush all |
| mnt_vpn | input | VPN_W | Page number for command 01 |
| rsp_valid | output | 1 | Response present |
| rsp_hit | output | 1 | Lookup hit |
| rsp_pfn | output | PFN_W | Frame number on hit, else zero |
| rsp_rw | output | 1 | Write permission of hit entry |
| rsp_us | output | 1 | User access of hit entry |
| rsp_dirty | output | 1 | Dirty bit of hit entry |
| rsp_global | output | 1 | Global bit of hit entry |

## Verification
The assertions check the cycle relations on every cycle. Every request gets exactly one response, and a miss carries zeros. A lookup never matches two ways at once. A lookup in the same cycle as a flush-all or an invalidate of its page misses, and one that meets a non-global flush can hit only a global entry. The replacement order, the survival of global entries across a switch flush, the address-space isolation and the fill-versus-maintenance ordering rest on stored state over many cycles. Only the bench's scenarios show them, with its reference model compared on every clock.

// File: rtl/tlb_pkg.sv
package tlb_pkg;
  typedef enum logic [1:0] {
    MNT_NONE     = 2'b00,
    MNT_INV_PAGE = 2'b01,
    MNT_FL_LOCAL = 2'b10,
    MNT_FL_ALL   = 2'b11
  } mnt_cmd_e;

  typedef struct packed {
    logic rw;
    logic us;
    logic dirty;
    logic glob;
  } attr_t;
endpackage

// File: rtl/tlb_way_match.sv
module tlb_way_match #(
  parameter int WAYS     = 4,
  parameter int TAG_W    = 17,
  parameter int ASID_W   = 4,
  parameter bit USE_ASID = 1'b1
) (
  input  logic [WAYS-1:0]        ent_valid,
  input  logic [WAYS-1:0]        ent_glob,
  input  logic [WAYS*TAG_W-1:0]  ent_tags,
  input  logic [WAYS*ASID_W-1:0] ent_asids,
  input  logic [TAG_W-1:0]       key_tag,
  input  logic [ASID_W-1:0]      key_asid,
  input  logic                   key_glob,
  output logic [WAYS-1:0]        hit
);
  // one comparator per way, all in parallel
  for (genvar w = 0; w < WAYS; w++) begin : g_way
    logic tag_eq;
    assign tag_eq = (ent_tags[w*TAG_W +: TAG_W] == key_tag);
    if (USE_ASID) begin : g_asid
      assign hit[w] = ent_valid[w] & tag_eq &
                      (ent_glob[w] | key_glob |
                       (ent_asids[w*ASID_W +: ASID_W] == key_asid));
    end else begin : g_noasid
      assign hit[w] = ent_valid[w] & tag_eq;
    end
  end
endmodule

// File: rtl/tlb_victim.sv
module tlb_victim #(
  parameter int WAYS  = 4,
  parameter int WAY_W = 2
) (
  input  logic [WAYS-1:0]  valid,
  input  logic [WAYS-1:0]  match,
  input  logic [WAY_W-1:0] ptr,
  output logic [WAY_W-1:0] way,
  output logic             use_ptr
);
  // priority: matching way, then lowest free way, then pointer
  always_comb begin
    way     = ptr;
    use_ptr = 1'b1;
    for (int w = WAYS - 1; w >= 0; w--) begin
      if (!valid[w]) begin
        way     = WAY_W'(w);
        use_ptr = 1'b0;
      end
    end
    for (int w = WAYS - 1; w >= 0; w--) begin
      if (match[w]) begin
        way     = WAY_W'(w);
        use_ptr = 1'b0;
      end
    end
  end
endmodule

// File: rtl/tlb_sa.sv
module tlb_sa
  import tlb_pkg::*;
#(
  parameter int SETS     = 8,
  parameter int WAYS     = 4,
  parameter int VPN_W    = 20,
  parameter int PFN_W    = 20,
  parameter int ASID_W   = 4,
  parameter bit USE_ASID = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              lk_valid,
  input  logic [VPN_W-1:0]  lk_vpn,
  input  logic [ASID_W-1:0] lk_asid,
  input  logic              fill_valid,
  input  logic [VPN_W-1:0]  fill_vpn,
  input  logic [ASID_W-1:0] fill_asid,
  input  logic [PFN_W-1:0]  fill_pfn,
  input  logic              fill_rw,
  input  logic              fill_us,
  input  logic              fill_dirty,
  input  logic              fill_global,
  input  logic [1:0]        mnt_cmd,
  input  logic [VPN_W-1:0]  mnt_vpn,
  output logic              rsp_valid,
  output logic              rsp_hit,
  output logic [PFN_W-1:0]  rsp_pfn,
  output logic              rsp_rw,
  output logic              rsp_us,
  output logic              rsp_dirty,
  output logic              rsp_global
);
  localparam int IDX_W = $clog2(SETS);
  localparam int TAG_W = VPN_W - IDX_W;
  localparam int WAY_W = (WAYS > 1) ? $clog2(WAYS) : 1;

  mnt_cmd_e cmd;
  assign cmd = mnt_cmd_e'(mnt_cmd);

  // storage
  logic [WAYS-1:0]   vld_q [SETS];
  logic [WAYS-1:0]   vld_d [SETS];
  logic [WAY_W-1:0]  rr_q  [SETS];
  logic [WAY_W-1:0]  rr_d  [SETS];
  logic [TAG_W-1:0]  tag_q  [SETS][WAYS];
  logic [ASID_W-1:0] asid_q [SETS][WAYS];
  logic [PFN_W-1:0]  pfn_q  [SETS][WAYS];
  attr_t             attr_q [SETS][WAYS];

  // address split
  logic [IDX_W-1:0] lk_idx, fl_idx, mn_idx;
  logic [TAG_W-1:0] lk_tag, fl_tag, mn_tag;
  assign lk_idx = lk_vpn[IDX_W-1:0];
  assign lk_tag = lk_vpn[VPN_W-1:IDX_W];
  assign fl_idx = fill_vpn[IDX_W-1:0];
  assign fl_tag = fill_vpn[VPN_W-1:IDX_W];
  assign mn_idx = mnt_vpn[IDX_W-1:0];
  assign mn_tag = mnt_vpn[VPN_W-1:IDX_W];

  // flattened views of the two addressed sets
  logic [WAYS*TAG_W-1:0]  lk_tags, fl_tags;
  logic [WAYS*ASID_W-1:0] lk_asids, fl_asids;
  logic [WAYS-1:0]        lk_glob, fl_glob;
  always_comb begin
    for (int w = 0; w < WAYS; w++) begin
      lk_tags[w*TAG_W +: TAG_W]    = tag_q[lk_idx][w];
      lk_asids[w*ASID_W +: ASID_W] = asid_q[lk_idx][w];
      lk_glob[w]                   = attr_q[lk_idx][w].glob;
      fl_tags[w*TAG_W +: TAG_W]    = tag_q[fl_idx][w];
      fl_asids[w*ASID_W +: ASID_W] = asid_q[fl_idx][w];
      fl_glob[w]                   = attr_q[fl_idx][w].glob;
    end
  end

  logic [WAYS-1:0] lk_hit_raw, fl_match;

  tlb_way_match #(.WAYS(WAYS), .TAG_W(TAG_W), .ASID_W(ASID_W), .USE_ASID(USE_ASID))
    u_lk_match (
      .ent_valid(vld_q[lk_idx]), .ent_glob(lk_glob), .ent_tags(lk_tags),
      .ent_asids(lk_asids), .key_tag(lk_tag), .key_asid(lk_asid),
      .key_glob(1'b0), .hit(lk_hit_raw));

  tlb_way_match #(.WAYS(WAYS), .TAG_W(TAG_W), .ASID_W(ASID_W), .USE_ASID(USE_ASID))
    u_fl_match (
      .ent_valid(vld_q[fl_idx]), .ent_glob(fl_glob), .ent_tags(fl_tags),
      .ent_asids(fl_asids), .key_tag(fl_tag), .key_asid(fill_asid),
      .key_glob(fill_global), .hit(fl_match));

  logic [WAY_W-1:0] fl_way;
  logic             fl_use_ptr;
  tlb_victim #(.WAYS(WAYS), .WAY_W(WAY_W)) u_victim (
    .valid(vld_q[fl_idx]), .match(fl_match), .ptr(rr_q[fl_idx]),
    .way(fl_way), .use_ptr(fl_use_ptr));

  // lookup sees the cache after this cycle's maintenance command
  logic [WAYS-1:0] lk_keep, lk_hit_vec;
  always_comb begin
    for (int w = 0; w < WAYS; w++) begin
      unique case (cmd)
        MNT_INV_PAGE: lk_keep[w] = !((mn_idx == lk_idx) && (tag_q[lk_idx][w] == mn_tag));
        MNT_FL_LOCAL: lk_keep[w] = lk_glob[w];
        MNT_FL_ALL:   lk_keep[w] = 1'b0;
        default:      lk_keep[w] = 1'b1;
      endcase
    end
  end
  assign lk_hit_vec = lk_hit_raw & lk_keep;

  // way multiplexer
  logic [PFN_W-1:0] sel_pfn;
  attr_t            sel_attr;
  always_comb begin
    sel_pfn  = '0;
    sel_attr = '0;
    for (int w = 0; w < WAYS; w++) begin
      sel_pfn  = sel_pfn  | ({PFN_W{lk_hit_vec[w]}} & pfn_q[lk_idx][w]);
      sel_attr = sel_attr | ({4{lk_hit_vec[w]}} & attr_q[lk_idx][w]);
    end
  end

  // next state: maintenance first, then fill
  always_comb begin
    for (int s = 0; s < SETS; s++) begin
      vld_d[s] = vld_q[s];
      rr_d[s]  = rr_q[s];
      for (int w = 0; w < WAYS; w++) begin
        if (cmd == MNT_FL_ALL)
          vld_d[s][w] = 1'b0;
        else if (cmd == MNT_FL_LOCAL && !attr_q[s][w].glob)
          vld_d[s][w] = 1'b0;
        else if (cmd == MNT_INV_PAGE && IDX_W'(s) == mn_idx && tag_q[s][w] == mn_tag)
          vld_d[s][w] = 1'b0;
      end
    end
    if (fill_valid) begin
      vld_d[fl_idx]         = vld_d[fl_idx] & ~fl_match;
      vld_d[fl_idx][fl_way] = 1'b1;
      if (fl_use_ptr)
        rr_d[fl_idx] = rr_q[fl_idx] + WAY_W'(1);
    end
  end

  // state registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int s = 0; s < SETS; s++) begin
        vld_q[s] <= '0;
        rr_q[s]  <= '0;
      end
    end else begin
      for (int s = 0; s < SETS; s++) begin
        vld_q[s] <= vld_d[s];
        rr_q[s]  <= rr_d[s];
      end
    end
  end

  // entry payload, written only on fill
  always_ff @(posedge clk) begin
    if (fill_valid) begin
      tag_q[fl_idx][fl_way]  <= fl_tag;
      asid_q[fl_idx][fl_way] <= fill_asid;
      pfn_q[fl_idx][fl_way]  <= fill_pfn;
      attr_q[fl_idx][fl_way] <= '{rw: fill_rw, us: fill_us, dirty: fill_dirty, glob: fill_global};
    end
  end

  // response registers
  attr_t rsp_attr_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid  <= 1'b0;
      rsp_hit    <= 1'b0;
      rsp_pfn    <= '0;
      rsp_attr_q <= '0;
    end else begin
      rsp_valid <= lk_valid;
      rsp_hit   <= lk_valid & (|lk_hit_vec);
      if (lk_valid) begin
        rsp_pfn    <= sel_pfn;
        rsp_attr_q <= sel_attr;
      end
    end
  end
  assign rsp_rw     = rsp_attr_q.rw;
  assign rsp_us     = rsp_attr_q.us;
  assign rsp_dirty  = rsp_attr_q.dirty;
  assign rsp_global = rsp_attr_q.glob;
endmodule

// File: rtl/tlb_sa_chk.sv
module tlb_sa_chk #(
  parameter int WAYS  = 4,
  parameter int VPN_W = 20,
  parameter int PFN_W = 20
) (
  input logic             clk,
  input logic             rst_n,
  input logic             lk_valid,
  input logic [VPN_W-1:0] lk_vpn,
  input logic [1:0]       mnt_cmd,
  input logic [VPN_W-1:0] mnt_vpn,
  input logic [WAYS-1:0]  lk_hit_raw,
  input logic             rsp_valid,
  input logic             rsp_hit,
  input logic [PFN_W-1:0] rsp_pfn,
  input logic             rsp_rw,
  input logic             rsp_us,
  input logic             rsp_dirty,
  input logic             rsp_global
);
  // R1
  rsp_follows_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    lk_valid |=> rsp_valid);
  // R1
  no_spurious_rsp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !lk_valid |=> (!rsp_valid && !rsp_hit));
  // R2
  miss_is_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_hit) |->
      (rsp_pfn == '0 && !rsp_rw && !rsp_us && !rsp_dirty && !rsp_global));
  // R4
  single_way_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(lk_hit_raw));
  // R9
  inv_same_cycle_miss_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (lk_valid && mnt_cmd == 2'b01 && mnt_vpn == lk_vpn) |=> !rsp_hit);
  // R8
  flush_all_same_cycle_miss_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (lk_valid && mnt_cmd == 2'b11) |=> !rsp_hit);
  // R7
  local_flush_keeps_global_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (lk_valid && mnt_cmd == 2'b10) |=> (!rsp_hit || rsp_global));
endmodule

bind tlb_sa tlb_sa_chk #(.WAYS(WAYS), .VPN_W(VPN_W), .PFN_W(PFN_W)) u_chk (.*);

// File: tb/tb_tlb_sa.sv
module tb_tlb_sa;
  localparam int NS = 8;
  localparam int NW = 4;
  localparam int VW = 20;
  localparam int PW = 20;
  localparam int AW = 4;

  logic clk = 1'b0;
  logic rst_n;
  logic lk_valid, fill_valid, fill_rw, fill_us, fill_dirty, fill_global;
  logic [VW-1:0] lk_vpn, fill_vpn, mnt_vpn;
  logic [AW-1:0] lk_asid, fill_asid;
  logic [PW-1:0] fill_pfn;
  logic [1:0] mnt_cmd;
  logic rsp_valid, rsp_hit, rsp_rw, rsp_us, rsp_dirty, rsp_global;
  logic [PW-1:0] rsp_pfn;

  always #10 clk = ~clk;

  tlb_sa #(.SETS(NS), .WAYS(NW), .VPN_W(VW), .PFN_W(PW), .ASID_W(AW), .USE_ASID(1'b1)) dut (
    .clk(clk), .rst_n(rst_n), .lk_valid(lk_valid), .lk_vpn(lk_vpn), .lk_asid(lk_asid),
    .fill_valid(fill_valid), .fill_vpn(fill_vpn), .fill_asid(fill_asid), .fill_pfn(fill_pfn),
    .fill_rw(fill_rw), .fill_us(fill_us), .fill_dirty(fill_dirty), .fill_global(fill_global),
    .mnt_cmd(mnt_cmd), .mnt_vpn(mnt_vpn), .rsp_valid(rsp_valid), .rsp_hit(rsp_hit),
    .rsp_pfn(rsp_pfn), .rsp_rw(rsp_rw), .rsp_us(rsp_us), .rsp_dirty(rsp_dirty),
    .rsp_global(rsp_global));

  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;

  // reference model; attribute bits held as {rw,us,dirty,global}
  bit m_v [NS][NW];
  int m_tag [NS][NW];
  int m_asid [NS][NW];
  int m_pfn [NS][NW];
  bit [3:0] m_attr [NS][NW];
  int m_rr [NS];

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic idle();
    lk_valid = 0; lk_vpn = '0; lk_asid = '0;
    fill_valid = 0; fill_vpn = '0; fill_asid = '0; fill_pfn = '0;
    fill_rw = 0; fill_us = 0; fill_dirty = 0; fill_global = 0;
    mnt_cmd = 2'b00; mnt_vpn = '0;
  endtask

  // one clock: predict, advance model, compare after the edge
  task automatic step(input string req);
    bit e_valid, e_hit;
    int e_pfn;
    bit [3:0] e_attr;
    int li, lt, mi, mt, fi, ft, way;
    bit nv [NS][NW];
    bit fm [NW];
    bit found;
    li = int'(lk_vpn) % NS; lt = int'(lk_vpn) / NS;
    mi = int'(mnt_vpn) % NS; mt = int'(mnt_vpn) / NS;
    fi = int'(fill_vpn) % NS; ft = int'(fill_vpn) / NS;
    e_valid = lk_valid; e_hit = 0; e_pfn = 0; e_attr = 0;
    if (lk_valid) begin
      for (int w = 0; w < NW; w++) begin
        bit alive;
        alive = 1;
        if (mnt_cmd == 2'b11) alive = 0;
        if (mnt_cmd == 2'b10 && !m_attr[li][w][0]) alive = 0;
        if (mnt_cmd == 2'b01 && mi == li && mt == m_tag[li][w]) alive = 0;
        if (alive && m_v[li][w] && m_tag[li][w] == lt &&
            (m_attr[li][w][0] || m_asid[li][w] == int'(lk_asid))) begin
          e_hit = 1; e_pfn = m_pfn[li][w]; e_attr = m_attr[li][w];
        end
      end
    end
    nv = m_v;
    for (int s = 0; s < NS; s++)
      for (int w = 0; w < NW; w++) begin
        if (mnt_cmd == 2'b11) nv[s][w] = 0;
        if (mnt_cmd == 2'b10 && !m_attr[s][w][0]) nv[s][w] = 0;
        if (mnt_cmd == 2'b01 && s == mi && m_tag[s][w] == mt) nv[s][w] = 0;
      end
    if (fill_valid) begin
      found = 0; way = 0;
      for (int w = 0; w < NW; w++)
        fm[w] = m_v[fi][w] && m_tag[fi][w] == ft &&
                (m_attr[fi][w][0] || fill_global || m_asid[fi][w] == int'(fill_asid));
      for (int w = 0; w < NW; w++) if (!found && fm[w]) begin found = 1; way = w; end
      for (int w = 0; w < NW; w++) if (!found && !m_v[fi][w]) begin found = 1; way = w; end
      if (!found) begin way = m_rr[fi]; m_rr[fi] = (m_rr[fi] + 1) % NW; end
      for (int w = 0; w < NW; w++) if (fm[w]) nv[fi][w] = 0;
      nv[fi][way] = 1;
      m_tag[fi][way] = ft; m_asid[fi][way] = int'(fill_asid); m_pfn[fi][way] = int'(fill_pfn);
      m_attr[fi][way] = {fill_rw, fill_us, fill_dirty, fill_global};
    end
    m_v = nv;
    @(posedge clk);
    #1;
    chk(rsp_valid == e_valid && rsp_hit == e_hit, req, "valid/hit",
        int'({rsp_valid, rsp_hit}), int'({e_valid, e_hit}));
    if (e_valid)
      chk(int'(rsp_pfn) == e_pfn && {rsp_rw, rsp_us, rsp_dirty, rsp_global} == e_attr,
          req, "pfn/attr", int'({rsp_pfn, rsp_rw, rsp_us, rsp_dirty, rsp_global}),
          int'({e_pfn[PW-1:0], e_attr}));
    @(negedge clk);
    idle();
  endtask

  task automatic look(input int vpn, input int asid, input string req);
    lk_valid = 1; lk_vpn = VW'(vpn); lk_asid = AW'(asid);
    step(req);
  endtask

  task automatic set_fill(input int vpn, input int asid, input int pfn, input bit [3:0] at);
    fill_valid = 1; fill_vpn = VW'(vpn); fill_asid = AW'(asid); fill_pfn = PW'(pfn);
    {fill_rw, fill_us, fill_dirty, fill_global} = at;
  endtask

  task automatic fill(input int vpn, input int asid, input int pfn, input bit [3:0] at, input string req);
    set_fill(vpn, asid, pfn, at);
    step(req);
  endtask

  function automatic int va(input int tg, input int idx);
    return tg * NS + idx;
  endfunction

  initial begin
    #(20 * 150000);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    for (int s = 0; s < NS; s++) begin
      m_rr[s] = 0;
      for (int w = 0; w < NW; w++) begin
        m_v[s][w] = 0; m_tag[s][w] = 0; m_asid[s][w] = 0; m_pfn[s][w] = 0; m_attr[s][w] = 0;
      end
    end
    idle();
    rst_n = 0;
    repeat (3) @(negedge clk);
    // R1: reset state
    chk(rsp_valid == 0 && rsp_hit == 0, "R1", "reset outputs", int'({rsp_valid, rsp_hit}), 0);
    rst_n = 1;
    @(negedge clk);
    step("R1");

    // R2 / R3: basic hit and address-space isolation
    fill(va(5, 0), 1, 'h1234, 4'b1010, "R2");
    look(va(5, 0), 1, "R2");
    look(va(5, 0), 2, "R3");
    look(va(6, 0), 1, "R2");
    fill(va(7, 0), 3, 'h0777, 4'b0111, "R3");
    look(va(7, 0), 9, "R3");
    // R4: refill of same page replaces in place
    fill(va(5, 0), 1, 'h4321, 4'b1100, "R4");
    look(va(5, 0), 1, "R4");
    fill(va(7, 0), 2, 'h0abc, 4'b0000, "R4");
    look(va(7, 0), 3, "R4");
    look(va(7, 0), 2, "R4");
    // R5: free-way then round-robin replacement in set 3
    for (int k = 0; k < 7; k++) begin
      fill(va(10 + k, 3), 0, 'h300 + k, 4'b1000, "R5");
      for (int j = 0; j < 7; j++) look(va(10 + j, 3), 0, "R5");
    end
    // R11: set independence
    look(va(5, 0), 1, "R11");
    fill(va(5, 2), 1, 'h0222, 4'b1000, "R11");
    look(va(5, 0), 1, "R11");
    look(va(5, 2), 1, "R11");
    // R6: single-page invalidate removes a global entry
    fill(va(9, 4), 0, 'h0900, 4'b0001, "R6");
    mnt_cmd = 2'b01; mnt_vpn = VW'(va(9, 4)); step("R6");
    look(va(9, 4), 5, "R6");
    // R9: same-cycle lookup and invalidate
    fill(va(9, 4), 0, 'h0901, 4'b0001, "R9");
    lk_valid = 1; lk_vpn = VW'(va(9, 4)); mnt_cmd = 2'b01; mnt_vpn = VW'(va(9, 4)); step("R9");
    // R7: non-global flush keeps globals
    fill(va(9, 4), 0, 'h0902, 4'b1101, "R7");
    fill(va(1, 4), 2, 'h0100, 4'b1100, "R7");
    lk_valid = 1; lk_vpn = VW'(va(1, 4)); lk_asid = 2; mnt_cmd = 2'b10; step("R7");
    look(va(9, 4), 6, "R7");
    look(va(1, 4), 2, "R7");
    // R8: flush all, and no-op command
    mnt_cmd = 2'b00; step("R8");
    look(va(9, 4), 0, "R8");
    lk_valid = 1; lk_vpn = VW'(va(9, 4)); mnt_cmd = 2'b11; step("R8");
    look(va(9, 4), 0, "R8");
    // R10: lookup with fill sees old state; fill after flush stays
    lk_valid = 1; lk_vpn = VW'(va(2, 6)); lk_asid = 1;
    set_fill(va(2, 6), 1, 'h0260, 4'b1000); step("R10");
    look(va(2, 6), 1, "R10");
    set_fill(va(3, 6), 1, 'h0360, 4'b0100); mnt_cmd = 2'b11; step("R10");
    look(va(3, 6), 1, "R10");
    set_fill(va(4, 6), 1, 'h0460, 4'b0010); mnt_cmd = 2'b01; mnt_vpn = VW'(va(4, 6)); step("R10");
    look(va(4, 6), 1, "R10");

    // mixed traffic against the model
    for (int n = 0; n < 4000; n++) begin
      int r;
      r = int'($urandom_range(0, 99));
      if (r < 60) begin
        lk_valid = 1; lk_vpn = VW'(va(int'($urandom_range(0, 5)), int'($urandom_range(0, NS - 1))));
        lk_asid = AW'($urandom_range(0, 3));
      end
      if (r >= 40 && r < 80)
        set_fill(va(int'($urandom_range(0, 5)), int'($urandom_range(0, NS - 1))),
                 int'($urandom_range(0, 3)), int'($urandom_range(0, 'hfffff)),
                 4'($urandom_range(0, 15)));
      if (r >= 95) begin
        mnt_cmd = 2'($urandom_range(1, 3));
        mnt_vpn = VW'(va(int'($urandom_range(0, 5)), int'($urandom_range(0, NS - 1))));
      end else if (r >= 88) begin
        mnt_cmd = 2'b01;
        mnt_vpn = VW'(va(int'($urandom_range(0, 5)), int'($urandom_range(0, NS - 1))));
      end
      step("R2");
    end

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule